// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block decides which parts of a chip are held in reset, for how long, and why. Four events can start a reset. The first is a power-up reset pin. The second is a software request bit. The third is a watchdog timer match while the watchdog is armed. The fourth is entry into sleep. Each event clears its own set of domains:

- the processor core domain;
- the memory-controller refresh/configuration domain;
- the always-on domain (power manager, real-time clock, wake-up register).

The block also drives a reset-out pin, a hold signal that keeps the DRAM strobes in self-refresh during sleep, and the power-enable output.

Software uses a small two-address register interface. Address 0 is the control word: it requests a software reset and arms the watchdog. The watchdog enable can be set by software but never cleared by it. Address 1 is the cause status word. It records which events caused the reset, and software clears its bits by writing 1s to them. The power-up pin acts at once when asserted. Its release is synchronized to the clock.

Top module: `rst_source_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n`, `mem_rst_n`, `aon_rst_n` and `rst_out_n` are low and `self_refresh_hold` is low, with no clock edge needed. After `ext_rst_n` rises, these resets are released on the SYNC_STAGES-th rising clock edge (default 2).
- R2: After a power-up reset, the status word at address 1 reads 4'b0001 and the control word at address 0 reads 0. The status bits are: bit0 power-up, bit1 software, bit2 watchdog, bit3 sleep.
- R3: A write of 1 to control bit0 at address 0 starts a software reset. During it, `core_rst_n` and `rst_out_n` are low while `mem_rst_n` and `aon_rst_n` stay high.
- R4: A software or watchdog reset keeps `core_rst_n` low for exactly HOLD_CYCLES clock cycles (default 256). The hold begins in the cycle after the triggering edge.
- R5: A write of 1 to control bit1 arms the watchdog. A write of 0 to that bit has no effect. The armed state reads back at address 0 bit1.
- R6: `wdog_match` while armed starts the same sequence as R3/R4 and sets status bit2. While the watchdog is not armed, `wdog_match` has no effect on the outputs or the status.
- R7: Every reset event (power-up, software, watchdog, sleep) disarms the watchdog.
- R8: A software request and an armed watchdog match in the same cycle set both status bit1 and bit2 and run one hold of HOLD_CYCLES.
- R9: A software request or watchdog match that arrives while a hold is running does not lengthen the hold and sets no status bit.
- R10: A write to address 1 clears each status bit written as 1 and leaves the others. Software, watchdog and sleep resets set their own bit and keep bits set earlier.
- R11: In the cycle after `sleep_req` is seen, `core_rst_n` and `mem_rst_n` are low, `self_refresh_hold` is high, and `aon_rst_n`, `rst_out_n` and `pwr_en` are high. One cycle later `pwr_en` goes low. Status bit3 is set.
- R12: While power is off, a low `sleep_req` raises `pwr_en` in the next cycle. `core_rst_n`, `mem_rst_n` and `self_refresh_hold` are released one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| ext_rst_n | input | 1 | Power-up reset pin, active low, asynchronous assertion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = cause status word |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for `reg_addr` (combinational) |
| wdog_match | input | 1 | Watchdog timer compare match |
| sleep_req | input | 1 | Sleep entry request, held for the whole sleep |
| core_rst_n | output | 1 | Core domain reset, active low |
| mem_rst_n | output | 1 | Memory-controller refresh/configuration reset, active low |
| aon_rst_n | output | 1 | Always-on domain reset, active low |
| rst_out_n | output | 1 | External reset-out pin, active low |
| self_refresh_hold | output | 1 | Holds DRAM strobes in self-refresh |
| pwr_en | output | 1 | Power enable for the switched domain |

## Verification
A software write and an armed watchdog match can land on the same clock edge. The bench sweeps every combination of software request, match and armed state. In each combination it drives both stimuli together on one edge. It then measures the low time of `core_rst_n` and reads back the cause bits and the armed state, comparing them with values computed from the stimulus. The bench also raises both kinds of request in the middle of a running hold. It judges those by the total hold length and by a status word that must not change.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   localparam int CAUSE_N = 4;
   localparam int CTL_SOFT = 0;
   localparam int CTL_ARM  = 1;

   typedef struct packed {
      logic slp;
      logic wd;
      logic sw;
      logic hw;
   } cause_t;

   typedef enum logic [1:0] {
      SLP_AWAKE,
      SLP_ENTER,
      SLP_OFF,
      SLP_WAKE
   } slp_state_e;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   logic [STAGES-1:0] q;

   if (STAGES < 2) begin : g_bad_stages
      $error("rstc_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) q[i] <= 1'b0;
            else         q[i] <= 1'b1;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) q[i] <= 1'b0;
            else         q[i] <= q[i-1];
         end
      end
   end

   assign rst_n = q[STAGES-1];
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
   parameter int HOLD = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD - 1);

   logic [CNT_W-1:0] cnt;

   if (HOLD < 2) begin : g_bad_hold
      $error("rstc_hold: HOLD must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
         end
      end else if (cnt == '0) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/rstc_sleep.sv
module rstc_sleep
   import rstc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic sleep_req,
   output logic active,
   output logic pwr_en
);
   slp_state_e state, nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         SLP_AWAKE: if (enter) nxt = SLP_ENTER;
         SLP_ENTER: nxt = SLP_OFF;
         SLP_OFF:   if (!sleep_req) nxt = SLP_WAKE;
         SLP_WAKE:  nxt = SLP_AWAKE;
         default:   nxt = SLP_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SLP_AWAKE;
      else        state <= nxt;
   end

   assign active = (state != SLP_AWAKE);
   assign pwr_en = (state != SLP_OFF);
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
   import rstc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               addr,
   input  logic [CAUSE_N-1:0] wdata,
   input  cause_t             set_cause,
   input  logic               any_event,
   output logic               soft_req,
   output logic               wdog_en,
   output cause_t             status,
   output logic [CAUSE_N-1:0] rdata
);
   logic               wr_ctl, wr_sts;
   logic [CAUSE_N-1:0] clr;

   assign wr_ctl   = wr && !addr;
   assign wr_sts   = wr && addr;
   assign soft_req = wr_ctl && wdata[CTL_SOFT];
   assign clr      = wr_sts ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= cause_t'(CAUSE_N'(1));
      else        status <= cause_t'((status & ~clr) | set_cause);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          wdog_en <= 1'b0;
      else if (any_event)                  wdog_en <= 1'b0;
      else if (wr_ctl && wdata[CTL_ARM])   wdog_en <= 1'b1;
   end

   always_comb begin
      rdata = '0;
      if (addr) rdata = status;
      else      rdata[CTL_ARM] = wdog_en;
   end
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
   import rstc_pkg::*;
#(
   parameter int HOLD_CYCLES = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               ext_rst_n,
   input  logic               reg_wr,
   input  logic               reg_addr,
   input  logic [CAUSE_N-1:0] reg_wdata,
   output logic [CAUSE_N-1:0] reg_rdata,
   input  logic               wdog_match,
   input  logic               sleep_req,
   output logic               core_rst_n,
   output logic               mem_rst_n,
   output logic               aon_rst_n,
   output logic               rst_out_n,
   output logic               self_refresh_hold,
   output logic               pwr_en
);
   logic   hw_rst_n;
   logic   busy, slp_active;
   logic   soft_req, wd_req, idle;
   logic   seq_start, slp_start;
   logic   wdog_en;
   cause_t status;
   cause_t set_cause;

   rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (ext_rst_n),
      .rst_n  (hw_rst_n)
   );

   assign wd_req    = wdog_en && wdog_match;
   assign idle      = !busy && !slp_active;
   assign seq_start = idle && (soft_req || wd_req);
   assign slp_start = idle && sleep_req && !(soft_req || wd_req);

   always_comb begin
      set_cause     = '0;
      set_cause.sw  = seq_start && soft_req;
      set_cause.wd  = seq_start && wd_req;
      set_cause.slp = slp_start;
   end

   rstc_hold #(.HOLD(HOLD_CYCLES)) u_hold (
      .clk   (clk),
      .rst_n (hw_rst_n),
      .start (seq_start),
      .busy  (busy)
   );

   rstc_sleep u_sleep (
      .clk       (clk),
      .rst_n     (hw_rst_n),
      .enter     (slp_start),
      .sleep_req (sleep_req),
      .active    (slp_active),
      .pwr_en    (pwr_en)
   );

   rstc_regs u_regs (
      .clk       (clk),
      .rst_n     (hw_rst_n),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .set_cause (set_cause),
      .any_event (seq_start || slp_start),
      .soft_req  (soft_req),
      .wdog_en   (wdog_en),
      .status    (status),
      .rdata     (reg_rdata)
   );

   assign aon_rst_n         = hw_rst_n;
   assign mem_rst_n         = hw_rst_n && !slp_active;
   assign core_rst_n        = hw_rst_n && !slp_active && !busy;
   assign rst_out_n         = hw_rst_n && !busy;
   assign self_refresh_hold = slp_active;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
   parameter int HOLD = 256
) (
   input logic       clk,
   input logic       ext_rst_n,
   input logic       core_rst_n,
   input logic       mem_rst_n,
   input logic       aon_rst_n,
   input logic       rst_out_n,
   input logic       self_refresh_hold,
   input logic       pwr_en,
   input logic       wdog_en,
   input logic [3:0] status
);
   int unsigned run;

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n)                 run <= 0;
      else if (!rst_out_n && aon_rst_n) run <= run + 1;
      else                            run <= 0;
   end

   AST_SOFT_KEEPS_MEM: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (!rst_out_n && aon_rst_n) |-> (mem_rst_n && !core_rst_n)); // R3

   AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (!ext_rst_n)
      ($rose(rst_out_n) && $past(aon_rst_n)) |-> (run == unsigned'(HOLD))); // R4

   AST_STATUS_AFTER_POWERUP: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $rose(aon_rst_n) |-> (status == 4'b0001)); // R2

   AST_DISARM_ON_EVENT: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $fell(wdog_en) |-> !core_rst_n); // R7

   AST_SLEEP_DOMAINS: assert property (@(posedge clk) disable iff (!ext_rst_n)
      self_refresh_hold |-> (aon_rst_n && rst_out_n && !mem_rst_n && !core_rst_n)); // R11

   AST_PWR_OFF_AFTER_RST: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $fell(pwr_en) |-> ($past(!core_rst_n) && $past(self_refresh_hold))); // R11

   AST_PWR_OFF_IN_SLEEP: assert property (@(posedge clk) disable iff (!ext_rst_n)
      !pwr_en |-> self_refresh_hold); // R12
endmodule

bind rst_source_ctrl rstc_checker #(.HOLD(HOLD_CYCLES)) u_chk (
   .clk               (clk),
   .ext_rst_n         (ext_rst_n),
   .core_rst_n        (core_rst_n),
   .mem_rst_n         (mem_rst_n),
   .aon_rst_n         (aon_rst_n),
   .rst_out_n         (rst_out_n),
   .self_refresh_hold (self_refresh_hold),
   .pwr_en            (pwr_en),
   .wdog_en           (wdog_en),
   .status            (status)
);

// File: tb/sim_rst_source_ctrl.sv
`timescale 1ns/1ps
module sim_rst_source_ctrl;
   localparam int HOLD = 256;

   logic       clk = 1'b0;
   logic       ext_rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       wdog_match = 1'b0;
   logic       sleep_req = 1'b0;
   logic       core_rst_n, mem_rst_n, aon_rst_n, rst_out_n;
   logic       self_refresh_hold, pwr_en;

   int  nchk = 0;
   int  nbad = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   rst_source_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
      .clk (clk), .ext_rst_n (ext_rst_n),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata), .wdog_match (wdog_match), .sleep_req (sleep_req),
      .core_rst_n (core_rst_n), .mem_rst_n (mem_rst_n), .aon_rst_n (aon_rst_n),
      .rst_out_n (rst_out_n), .self_refresh_hold (self_refresh_hold), .pwr_en (pwr_en)
   );

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [3:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [3:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic hold_len(output int n, output int bad_dom);
      n = 0; bad_dom = 0;
      while (core_rst_n == 1'b0 && n < 2000) begin
         n++;
         if (mem_rst_n !== 1'b1 || aon_rst_n !== 1'b1 || rst_out_n !== 1'b0) bad_dom++;
         tick();
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", nchk, nbad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++; nbad++;
         $display("FAIL R4 watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [3:0] v;
      int n, bd;

      // R1: asynchronous assertion before any clock edge
      #1;
      check("R1 core low in pin reset", core_rst_n, 0);
      check("R1 mem low in pin reset", mem_rst_n, 0);
      check("R1 aon low in pin reset", aon_rst_n, 0);
      check("R1 rst_out low in pin reset", rst_out_n, 0);
      check("R1 self-refresh low in pin reset", self_refresh_hold, 0);
      repeat (3) tick();
      ext_rst_n = 1'b1;
      tick();
      check("R1 still held after one edge", aon_rst_n, 0);
      tick();
      check("R1 aon released after two edges", aon_rst_n, 1);
      check("R1 core released", core_rst_n, 1);
      check("R1 mem released", mem_rst_n, 1);
      check("R1 rst_out released", rst_out_n, 1);
      check("R11 pwr_en high when awake", pwr_en, 1);
      rd(1'b1, v); check("R2 status after power-up", v, 4'b0001);
      rd(1'b0, v); check("R2 control after power-up", v, 0);
      tick();

      // Sweep: software request x watchdog match x armed (R3 R4 R6 R8)
      for (int en = 0; en < 2; en++) begin
         for (int sw = 0; sw < 2; sw++) begin
            for (int wd = 0; wd < 2; wd++) begin
               int trig;
               int exp_sts;
               wr(1'b1, 4'hF);
               if (en != 0) wr(1'b0, 4'b0010);
               reg_addr = 1'b0; reg_wdata = 4'b0001;
               reg_wr = sw[0]; wdog_match = wd[0];
               tick();
               reg_wr = 1'b0; wdog_match = 1'b0;
               trig = sw | (en & wd);
               exp_sts = (sw << 1) | ((en & wd) << 2);
               if (trig == 0) exp_sts = 0;
               hold_len(n, bd);
               check($sformatf("R4/R8 hold length en=%0d sw=%0d wd=%0d", en, sw, wd),
                     n, (trig != 0) ? HOLD : 0);
               check("R3 domains during hold", bd, 0);
               rd(1'b1, v);
               check($sformatf("R6/R8 status en=%0d sw=%0d wd=%0d", en, sw, wd), v, exp_sts);
               rd(1'b0, v);
               check("R7 armed state after sweep step", v, (trig != 0) ? 0 : (en << 1));
               tick();
            end
         end
      end

      // R5: arming is sticky
      wr(1'b0, 4'b0010);
      rd(1'b0, v); check("R5 armed after write 1", v, 4'b0010);
      tick();
      wr(1'b0, 4'b0000);
      rd(1'b0, v); check("R5 write 0 leaves armed", v, 4'b0010);
      tick();

      // R9: watchdog-triggered hold, more requests in the middle
      wr(1'b1, 4'hF);
      wdog_match = 1'b1;
      tick();
      wdog_match = 1'b0;
      n = 0; bd = 0;
      while (core_rst_n == 1'b0 && n < 2000) begin
         n++;
         if (n == 100) begin
            reg_addr = 1'b0; reg_wdata = 4'b0011; reg_wr = 1'b1; wdog_match = 1'b1;
         end else begin
            reg_wr = 1'b0; wdog_match = 1'b0;
         end
         tick();
      end
      reg_wr = 1'b0; wdog_match = 1'b0;
      check("R9 hold not extended", n, HOLD);
      rd(1'b1, v); check("R9 status only watchdog", v, 4'b0100);
      tick();

      // R11 R12: sleep entry and wake
      sleep_req = 1'b1;
      tick();
      check("R11 core low in sleep", core_rst_n, 0);
      check("R11 mem low in sleep", mem_rst_n, 0);
      check("R11 aon kept in sleep", aon_rst_n, 1);
      check("R11 rst_out kept in sleep", rst_out_n, 1);
      check("R11 self-refresh held", self_refresh_hold, 1);
      check("R11 pwr_en still high", pwr_en, 1);
      tick();
      check("R11 pwr_en low", pwr_en, 0);
      repeat (3) tick();
      check("R11 pwr_en stays low", pwr_en, 0);
      sleep_req = 1'b0;
      tick();
      check("R12 pwr_en back", pwr_en, 1);
      check("R12 core still held", core_rst_n, 0);
      check("R12 self-refresh still held", self_refresh_hold, 1);
      tick();
      check("R12 core released", core_rst_n, 1);
      check("R12 mem released", mem_rst_n, 1);
      check("R12 self-refresh released", self_refresh_hold, 0);
      rd(1'b1, v); check("R10 sleep bit added to earlier", v, 4'b1100);
      rd(1'b0, v); check("R7 sleep disarms watchdog", v, 0);
      tick();

      // R10: write-1-to-clear
      wr(1'b1, 4'b0100);
      rd(1'b1, v); check("R10 clear selected bit", v, 4'b1000);
      tick();
      wr(1'b1, 4'b0000);
      rd(1'b1, v); check("R10 write 0 keeps bits", v, 4'b1000);
      tick();

      // R1 R2 R7: pin reset in mid-operation
      wr(1'b0, 4'b0010);
      #1;
      ext_rst_n = 1'b0;
      #1;
      check("R1 async assertion of aon", aon_rst_n, 0);
      check("R1 async assertion of rst_out", rst_out_n, 0);
      tick(); tick();
      ext_rst_n = 1'b1;
      tick(); tick();
      check("R1 release after pin reset", core_rst_n, 1);
      rd(1'b1, v); check("R2 status only power-up", v, 4'b0001);
      rd(1'b0, v); check("R7 pin reset disarms", v, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule